// File: doc/BRIEF.md
# Region-Based Bus Access Guard

This block sits on one bus path between a single AHB-style master port and a single slave. It holds a bank of address-range descriptors. Each descriptor has an inclusive start and end address at 32-byte granularity, a rights word and a valid bit. Every transfer the master issues is checked against these descriptors in its address phase. The check looks at the address, the master ID, the privilege level and whether the transfer is a read or a write. A transfer that is allowed goes to the slave untouched. A transfer that is refused never reaches the slave. Instead, the master gets a two-cycle ERROR response, and the first such fault is recorded for software.

Software programs the guard through a 32-bit register port. Writes to a descriptor's bounds or rights drop its valid bit, so a partly written descriptor is never used. A separate rights-only alias changes the permissions without touching validity. A global enable bit is clear after reset. While it is clear, the guard is fully transparent.

Top module: `rgn_guard`

## Requirements
- R1: After reset the control register reads 0 (global enable bit 0 clear). While the enable is clear, every transfer is forwarded to the slave unchanged, whatever the descriptors hold.
- R2: With the enable set, a transfer whose address lies in no valid descriptor is refused.
- R3: A refused transfer is not forwarded: s_htrans reads IDLE (0) during its address phase. Its data phase returns m_hready=0, m_hresp=1 in the first cycle, then m_hready=1, m_hresp=1 in the second.
- R4: An allowed transfer appears on the slave side with the same htrans, address, write flag, size, privilege and master ID. The write data passes through. The slave's hrdata, hready and hresp return to the master.
- R5: Writing descriptor word 3 loads the valid bit from bit 0 (1 creates, 0 deletes). Any write to words 0, 1 or 2 of a descriptor clears its valid bit.
- R6: A write to a descriptor's rights alias replaces its rights word and leaves its valid bit unchanged. The new rights govern the next transfer.
- R7: Word 0 keeps address bits 31:5 and reads back with bits 4:0 as 0. Word 1 keeps bits 31:5 and reads back with bits 4:0 as 1. A transfer matches when start <= address <= end, both ends included.
- R8: In the rights word, the bits for master m sit at 4m: 4m = privileged read, 4m+1 = privileged write, 4m+2 = user read, 4m+3 = user write.
- R9: A transfer is allowed when at least one valid matching descriptor grants the needed right, even if other matching descriptors do not.
- R10: On a refused transfer, the error-address register (0x004) captures the address. The error-detail register (0x008) captures the master ID in bits 1:0, the write flag in bit 8 and the privilege flag in bit 9.
- R11: The error flag (control bit 8) is set with the first capture and cleared by writing 1 to it. While it is set, later faults leave both capture registers unchanged.
- R12: Register map by byte address: 0x000 control, 0x004 error address, 0x008 error detail. Descriptor n, word w is at 0x100 + 16n + 4w. The rights alias for descriptor n is at 0x200 + 4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| m_htrans | input | 2 | Master transfer type |
| m_haddr | input | 32 | Master address |
| m_hwrite | input | 1 | Master write flag |
| m_hsize | input | 3 | Master transfer size |
| m_hpriv | input | 1 | Master privileged flag |
| m_hmaster | input | 2 | Master ID |
| m_hwdata | input | 32 | Master write data |
| m_hrdata | output | 32 | Read data to master |
| m_hready | output | 1 | Ready to master |
| m_hresp | output | 1 | Response to master (1 = ERROR) |
| s_htrans | output | 2 | Transfer type to slave |
| s_haddr | output | 32 | Address to slave |
| s_hwrite | output | 1 | Write flag to slave |
| s_hsize | output | 3 | Size to slave |
| s_hpriv | output | 1 | Privileged flag to slave |
| s_hmaster | output | 2 | Master ID to slave |
| s_hwdata | output | 32 | Write data to slave |
| s_hreadyin | output | 1 | Combined bus ready seen by slave |
| s_hrdata | input | 32 | Slave read data |
| s_hready | input | 1 | Slave ready |
| s_hresp | input | 1 | Slave response |

## Verification
The bench hits both inclusive bounds exactly and one granule outside each. An off-by-one comparator would allow or refuse the wrong one of these. It changes a bound of a live descriptor and expects refusal, then re-arms it. A design that left the valid bit set would let the stale range through. It uses the rights alias on a live descriptor and issues a transfer right after. A wrong design would either drop validity or apply the rights late. It also sets up overlapping descriptors with disjoint rights, which catches a design that looks only at the first match. Finally, it provokes a second fault while the flag is up, which catches capture registers that get overwritten.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;
    localparam int NMST   = 4;
    localparam int MST_W  = $clog2(NMST);
    localparam int GRAN   = 5;
    localparam int BND_W  = 32 - GRAN;
    localparam int RT_W   = 4 * NMST;
    localparam int RIDX_W = MST_W + 2;

    localparam logic [1:0] HT_IDLE = 2'b00;

    typedef enum logic [1:0] {
        GS_PASS = 2'd0,
        GS_ERR1 = 2'd1,
        GS_ERR2 = 2'd2
    } gate_st_t;

    typedef struct packed {
        logic             priv;
        logic             wr;
        logic [MST_W-1:0] mst;
    } fault_info_t;
endpackage

// File: rtl/rgn_guard_regs.sv
module rgn_guard_regs
    import rgn_guard_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [9:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic                         fault_evt,
    input  logic [31:0]                  fault_addr,
    input  fault_info_t                  fault_info,
    output logic                         en,
    output logic [NREG-1:0][BND_W-1:0]   rg_lo,
    output logic [NREG-1:0][BND_W-1:0]   rg_hi,
    output logic [NREG-1:0][RT_W-1:0]    rg_rt,
    output logic [NREG-1:0]              rg_vld
);
    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        logic                       en;
        logic                       flag;
        logic [31:0]                eaddr;
        fault_info_t                einfo;
        logic [NREG-1:0][BND_W-1:0] lo;
        logic [NREG-1:0][BND_W-1:0] hi;
        logic [NREG-1:0][RT_W-1:0]  rt;
        logic [NREG-1:0]            vld;
    } regs_t;

    regs_t r_d, r_q;

    logic             is_ctrl, is_eaddr, is_einfo, is_desc, is_alt, clr_w;
    logic [IDX_W-1:0] d_idx, a_idx;
    logic [1:0]       d_word;

    always_comb begin
        is_ctrl  = (reg_addr[9:2] == 8'd0);
        is_eaddr = (reg_addr[9:2] == 8'd1);
        is_einfo = (reg_addr[9:2] == 8'd2);
        is_desc  = (reg_addr[9:8] == 2'b01) && (int'(reg_addr[7:4]) < NREG);
        is_alt   = (reg_addr[9:8] == 2'b10) && (reg_addr[7:6] == 2'b00)
                   && (int'(reg_addr[5:2]) < NREG);
        d_idx    = reg_addr[4 +: IDX_W];
        a_idx    = reg_addr[2 +: IDX_W];
        d_word   = reg_addr[3:2];
        clr_w    = reg_we && is_ctrl && reg_wdata[8];
    end

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            if (is_ctrl) begin
                r_d.en = reg_wdata[0];
                if (reg_wdata[8]) r_d.flag = 1'b0;
            end
            if (is_desc) begin
                case (d_word)
                    2'd0: begin
                        r_d.lo[d_idx]  = reg_wdata[31:GRAN];
                        r_d.vld[d_idx] = 1'b0;
                    end
                    2'd1: begin
                        r_d.hi[d_idx]  = reg_wdata[31:GRAN];
                        r_d.vld[d_idx] = 1'b0;
                    end
                    2'd2: begin
                        r_d.rt[d_idx]  = reg_wdata[RT_W-1:0];
                        r_d.vld[d_idx] = 1'b0;
                    end
                    default: r_d.vld[d_idx] = reg_wdata[0];
                endcase
            end
            if (is_alt) r_d.rt[a_idx] = reg_wdata[RT_W-1:0];
        end
        if (fault_evt && (!r_q.flag || clr_w)) begin
            r_d.flag  = 1'b1;
            r_d.eaddr = fault_addr;
            r_d.einfo = fault_info;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (is_ctrl) begin
            reg_rdata[0] = r_q.en;
            reg_rdata[8] = r_q.flag;
        end else if (is_eaddr) begin
            reg_rdata = r_q.eaddr;
        end else if (is_einfo) begin
            reg_rdata[MST_W-1:0] = r_q.einfo.mst;
            reg_rdata[8]         = r_q.einfo.wr;
            reg_rdata[9]         = r_q.einfo.priv;
        end else if (is_desc) begin
            case (d_word)
                2'd0:    reg_rdata = {r_q.lo[d_idx], {GRAN{1'b0}}};
                2'd1:    reg_rdata = {r_q.hi[d_idx], {GRAN{1'b1}}};
                2'd2:    reg_rdata[RT_W-1:0] = r_q.rt[d_idx];
                default: reg_rdata[0] = r_q.vld[d_idx];
            endcase
        end else if (is_alt) begin
            reg_rdata[RT_W-1:0] = r_q.rt[a_idx];
        end
    end

    assign en     = r_q.en;
    assign rg_lo  = r_q.lo;
    assign rg_hi  = r_q.hi;
    assign rg_rt  = r_q.rt;
    assign rg_vld = r_q.vld;

    // R5: a bound or rights write leaves the region invalid afterwards
    for (genvar i = 0; i < NREG; i++) begin : g_vchk
        a_r5_word_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && is_desc && (int'(d_idx) == i) && (d_word != 2'd3)) |=> !r_q.vld[i]);
    end

    // R6: alias writes never alter validity
    a_r6_alias_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && is_alt && !is_desc) |=> $stable(r_q.vld));

    // R11: capture frozen while flag is up and not being cleared
    a_r11_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !clr_w) |=> ($stable(r_q.eaddr) && $stable(r_q.einfo)));

    // R11: a fault always leaves the flag set
    a_r11_flag_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> r_q.flag);
endmodule

// File: rtl/rgn_guard_match.sv
module rgn_guard_match
    import rgn_guard_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [31:0]                addr,
    input  logic [MST_W-1:0]           mst,
    input  logic                       priv,
    input  logic                       wr,
    input  logic [NREG-1:0][BND_W-1:0] rg_lo,
    input  logic [NREG-1:0][BND_W-1:0] rg_hi,
    input  logic [NREG-1:0][RT_W-1:0]  rg_rt,
    input  logic [NREG-1:0]            rg_vld,
    output logic                       allow
);
    logic [RIDX_W-1:0] ridx;
    logic [NREG-1:0]   hit;

    assign ridx = {mst, ~priv, wr};

    for (genvar i = 0; i < NREG; i++) begin : g_rgn
        logic in_lo, in_hi;
        always_comb begin
            in_lo  = (addr[31:GRAN] >= rg_lo[i]);
            in_hi  = (addr[31:GRAN] <= rg_hi[i]);
            hit[i] = rg_vld[i] && in_lo && in_hi && rg_rt[i][ridx];
        end
    end

    assign allow = !en || (|hit);

    // R1: disabled guard never refuses
    a_r1_disabled_allows: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> allow);

    // R2: no valid region means refusal when enabled
    a_r2_empty_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (rg_vld == '0)) |-> !allow);
endmodule

// File: rtl/rgn_guard_gate.sv
module rgn_guard_gate
    import rgn_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        allow,
    input  logic [1:0]  m_htrans,
    input  logic [31:0] m_haddr,
    input  logic        m_hwrite,
    input  logic        m_hpriv,
    input  logic [MST_W-1:0] m_hmaster,
    output logic [31:0] m_hrdata,
    output logic        m_hready,
    output logic        m_hresp,
    output logic [1:0]  s_htrans,
    input  logic [31:0] s_hrdata,
    input  logic        s_hready,
    input  logic        s_hresp,
    output logic        fault_evt,
    output logic [31:0] fault_addr,
    output fault_info_t fault_info
);
    typedef struct packed {
        gate_st_t st;
    } gate_t;

    gate_t g_d, g_q;
    logic  deny, accept;

    always_comb begin
        unique case (g_q.st)
            GS_ERR1: m_hready = 1'b0;
            GS_ERR2: m_hready = 1'b1;
            default: m_hready = s_hready;
        endcase
        m_hresp   = (g_q.st == GS_PASS) ? s_hresp  : 1'b1;
        m_hrdata  = (g_q.st == GS_PASS) ? s_hrdata : '0;
        deny      = m_htrans[1] && !allow;
        accept    = m_htrans[1] && m_hready;
        s_htrans  = ((g_q.st == GS_ERR1) || deny) ? HT_IDLE : m_htrans;
        fault_evt = accept && deny;
        fault_addr      = m_haddr;
        fault_info.mst  = m_hmaster;
        fault_info.wr   = m_hwrite;
        fault_info.priv = m_hpriv;

        g_d = g_q;
        if (g_q.st == GS_ERR1)  g_d.st = GS_ERR2;
        else if (fault_evt)     g_d.st = GS_ERR1;
        else                    g_d.st = GS_PASS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '{st: GS_PASS};
        else        g_q <= g_d;
    end

    // R3: first error cycle stalls with ERROR
    a_r3_err_first: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> (!m_hready && m_hresp));

    // R3: second error cycle completes with ERROR
    a_r3_err_second: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == GS_ERR1) |=> (m_hready && m_hresp));

    // R3: nothing reaches the slave during the stall cycle
    a_r3_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == GS_ERR1) |-> (s_htrans == HT_IDLE));
endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
    import rgn_guard_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [9:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  m_htrans,
    input  logic [31:0] m_haddr,
    input  logic        m_hwrite,
    input  logic [2:0]  m_hsize,
    input  logic        m_hpriv,
    input  logic [MST_W-1:0] m_hmaster,
    input  logic [31:0] m_hwdata,
    output logic [31:0] m_hrdata,
    output logic        m_hready,
    output logic        m_hresp,
    output logic [1:0]  s_htrans,
    output logic [31:0] s_haddr,
    output logic        s_hwrite,
    output logic [2:0]  s_hsize,
    output logic        s_hpriv,
    output logic [MST_W-1:0] s_hmaster,
    output logic [31:0] s_hwdata,
    output logic        s_hreadyin,
    input  logic [31:0] s_hrdata,
    input  logic        s_hready,
    input  logic        s_hresp
);
    logic                       en_w, allow_w, fault_w;
    logic [31:0]                faddr_w;
    fault_info_t                finfo_w;
    logic [NREG-1:0][BND_W-1:0] lo_w, hi_w;
    logic [NREG-1:0][RT_W-1:0]  rt_w;
    logic [NREG-1:0]            vld_w;

    rgn_guard_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_evt(fault_w), .fault_addr(faddr_w), .fault_info(finfo_w),
        .en(en_w), .rg_lo(lo_w), .rg_hi(hi_w), .rg_rt(rt_w), .rg_vld(vld_w)
    );

    rgn_guard_match #(.NREG(NREG)) u_match (
        .clk(clk), .rst_n(rst_n), .en(en_w),
        .addr(m_haddr), .mst(m_hmaster), .priv(m_hpriv), .wr(m_hwrite),
        .rg_lo(lo_w), .rg_hi(hi_w), .rg_rt(rt_w), .rg_vld(vld_w),
        .allow(allow_w)
    );

    rgn_guard_gate u_gate (
        .clk(clk), .rst_n(rst_n), .allow(allow_w),
        .m_htrans(m_htrans), .m_haddr(m_haddr), .m_hwrite(m_hwrite),
        .m_hpriv(m_hpriv), .m_hmaster(m_hmaster),
        .m_hrdata(m_hrdata), .m_hready(m_hready), .m_hresp(m_hresp),
        .s_htrans(s_htrans), .s_hrdata(s_hrdata), .s_hready(s_hready), .s_hresp(s_hresp),
        .fault_evt(fault_w), .fault_addr(faddr_w), .fault_info(finfo_w)
    );

    assign s_haddr    = m_haddr;
    assign s_hwrite   = m_hwrite;
    assign s_hsize    = m_hsize;
    assign s_hpriv    = m_hpriv;
    assign s_hmaster  = m_hmaster;
    assign s_hwdata   = m_hwdata;
    assign s_hreadyin = m_hready;

    // R1: disabled for three cycles means transfer type passes untouched
    a_r1_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_w && $past(!en_w) && $past(!en_w, 2)) |-> (s_htrans == m_htrans));
endmodule

// File: tb/rgn_guard_bench.sv
module rgn_guard_bench;
    localparam logic [31:0] SLV_DATA = 32'hC0FF_EE01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  m_htrans = 2'b00;
    logic [31:0] m_haddr = '0;
    logic        m_hwrite = 1'b0;
    logic [2:0]  m_hsize = 3'd2;
    logic        m_hpriv = 1'b0;
    logic [1:0]  m_hmaster = '0;
    logic [31:0] m_hwdata = '0;
    logic [31:0] m_hrdata;
    logic        m_hready, m_hresp;
    logic [1:0]  s_htrans;
    logic [31:0] s_haddr, s_hwdata;
    logic        s_hwrite, s_hpriv, s_hreadyin;
    logic [2:0]  s_hsize;
    logic [1:0]  s_hmaster;
    logic [31:0] s_hrdata = SLV_DATA;
    logic        s_hready = 1'b1;
    logic        s_hresp = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rgn_guard u_rgn_guard (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .m_htrans(m_htrans), .m_haddr(m_haddr), .m_hwrite(m_hwrite), .m_hsize(m_hsize),
        .m_hpriv(m_hpriv), .m_hmaster(m_hmaster), .m_hwdata(m_hwdata),
        .m_hrdata(m_hrdata), .m_hready(m_hready), .m_hresp(m_hresp),
        .s_htrans(s_htrans), .s_haddr(s_haddr), .s_hwrite(s_hwrite), .s_hsize(s_hsize),
        .s_hpriv(s_hpriv), .s_hmaster(s_hmaster), .s_hwdata(s_hwdata), .s_hreadyin(s_hreadyin),
        .s_hrdata(s_hrdata), .s_hready(s_hready), .s_hresp(s_hresp)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic xfer(input logic [31:0] a, input logic wr, input logic priv,
                        input logic [1:0] mst, input bit exp_ok, input string req);
        logic [31:0] wd;
        wd = a ^ 32'h5A5A_0000;
        @(negedge clk);
        m_htrans = 2'b10; m_haddr = a; m_hwrite = wr; m_hpriv = priv; m_hmaster = mst;
        #1;
        if (exp_ok) begin
            chk(s_htrans == 2'b10 && s_haddr == a && s_hwrite == wr && s_hpriv == priv
                && s_hmaster == mst && s_hsize == m_hsize, req, {30'd0, s_htrans}, 32'd2);
        end else begin
            chk(s_htrans == 2'b00, req, {30'd0, s_htrans}, 32'd0);
        end
        @(negedge clk);
        m_htrans = 2'b00; m_hwdata = wd;
        #1;
        if (exp_ok) begin
            chk(m_hready && !m_hresp, req, {30'd0, m_hready, m_hresp}, 32'h2);
            if (wr) chk(s_hwdata == wd, req, s_hwdata, wd);
            else    chk(m_hrdata == SLV_DATA, req, m_hrdata, SLV_DATA);
        end else begin
            chk(!m_hready && m_hresp, req, {30'd0, m_hready, m_hresp}, 32'h1);
            @(negedge clk);
            #1;
            chk(m_hready && m_hresp, req, {30'd0, m_hready, m_hresp}, 32'h3);
        end
    endtask

    task automatic t_reset;
        reg_chk(10'h000, 32'h0, "R1 ctrl after reset");
        reg_chk(10'h004, 32'h0, "R12 error address after reset");
        xfer(32'h0000_1234, 1'b0, 1'b0, 2'd0, 1'b1, "R1 R4 disabled read passes");
        xfer(32'h8000_0040, 1'b1, 1'b1, 2'd2, 1'b1, "R1 R4 disabled write passes");
    endtask

    task automatic t_empty;
        reg_wr(10'h000, 32'h1);
        reg_chk(10'h000, 32'h1, "R12 ctrl enable readback");
        xfer(32'h0000_4000, 1'b1, 1'b1, 2'd3, 1'b0, "R2 R3 no region refuses");
        reg_chk(10'h004, 32'h0000_4000, "R10 error address");
        reg_chk(10'h008, 32'h0000_0303, "R10 error detail");
        reg_chk(10'h000, 32'h101, "R11 flag set");
    endtask

    task automatic t_region;
        reg_wr(10'h100, 32'h1000_0013);
        reg_wr(10'h104, 32'h1000_00E0);
        reg_wr(10'h108, 32'h0000_0030);
        reg_wr(10'h10C, 32'h1);
        reg_chk(10'h100, 32'h1000_0000, "R7 start low bits zero");
        reg_chk(10'h104, 32'h1000_00FF, "R7 end low bits one");
        reg_chk(10'h108, 32'h0000_0030, "R12 rights word readback");
        reg_chk(10'h10C, 32'h1, "R5 valid set by word 3");
        xfer(32'h1000_00FF, 1'b0, 1'b1, 2'd1, 1'b1, "R7 end inclusive");
        xfer(32'h1000_0000, 1'b1, 1'b1, 2'd1, 1'b1, "R7 R8 start inclusive write");
        xfer(32'h1000_0100, 1'b0, 1'b1, 2'd1, 1'b0, "R7 past end refused");
        xfer(32'h0FFF_FFE0, 1'b0, 1'b1, 2'd1, 1'b0, "R7 below start refused");
        xfer(32'h1000_0040, 1'b0, 1'b0, 2'd1, 1'b0, "R8 user read not granted");
        xfer(32'h1000_0040, 1'b0, 1'b1, 2'd2, 1'b0, "R8 other master not granted");
    endtask

    task automatic t_capture;
        reg_chk(10'h004, 32'h0000_4000, "R11 first fault address held");
        reg_chk(10'h008, 32'h0000_0303, "R11 first fault detail held");
        reg_wr(10'h000, 32'h101);
        reg_chk(10'h000, 32'h1, "R11 flag cleared by write 1");
        xfer(32'h1000_0104, 1'b0, 1'b0, 2'd2, 1'b0, "R2 outside region");
        reg_chk(10'h004, 32'h1000_0104, "R10 R11 new fault captured");
        reg_chk(10'h008, 32'h0000_0002, "R10 new detail captured");
    endtask

    task automatic t_valid;
        reg_wr(10'h104, 32'h1000_00FF);
        reg_chk(10'h10C, 32'h0, "R5 bound write clears valid");
        xfer(32'h1000_0020, 1'b0, 1'b1, 2'd1, 1'b0, "R5 invalid region refuses");
        reg_wr(10'h10C, 32'h1);
        xfer(32'h1000_0020, 1'b0, 1'b1, 2'd1, 1'b1, "R5 rearmed region allows");
        reg_wr(10'h108, 32'h0000_0030);
        reg_chk(10'h10C, 32'h0, "R5 rights word write clears valid");
        reg_wr(10'h10C, 32'h1);
        reg_wr(10'h10C, 32'h0);
        xfer(32'h1000_0020, 1'b0, 1'b1, 2'd1, 1'b0, "R5 deleted region refuses");
    endtask

    task automatic t_alias;
        reg_wr(10'h200, 32'h0000_0400);
        reg_chk(10'h10C, 32'h0, "R6 alias leaves invalid region invalid");
        reg_chk(10'h108, 32'h0000_0400, "R6 R12 alias updates rights");
        reg_wr(10'h10C, 32'h1);
        reg_wr(10'h200, 32'h0000_0030);
        xfer(32'h1000_0020, 1'b0, 1'b1, 2'd1, 1'b1, "R6 alias rights active next");
        reg_wr(10'h200, 32'h0000_0400);
        xfer(32'h1000_0020, 1'b0, 1'b0, 2'd2, 1'b1, "R6 R8 new rights apply");
        xfer(32'h1000_0020, 1'b0, 1'b1, 2'd1, 1'b0, "R6 old rights revoked");
        reg_chk(10'h10C, 32'h1, "R6 alias keeps valid set");
    endtask

    task automatic t_overlap;
        reg_wr(10'h110, 32'h2000_0000);
        reg_wr(10'h114, 32'h2000_0FFF);
        reg_wr(10'h118, 32'h0000_0004);
        reg_wr(10'h11C, 32'h1);
        reg_wr(10'h120, 32'h2000_0800);
        reg_wr(10'h124, 32'h2000_1FFF);
        reg_wr(10'h128, 32'h0000_0008);
        reg_wr(10'h12C, 32'h1);
        xfer(32'h2000_0900, 1'b1, 1'b0, 2'd0, 1'b1, "R9 write via second region");
        xfer(32'h2000_0900, 1'b0, 1'b0, 2'd0, 1'b1, "R9 read via first region");
        xfer(32'h2000_0100, 1'b1, 1'b0, 2'd0, 1'b0, "R9 write outside grant");
        xfer(32'h2000_1800, 1'b0, 1'b0, 2'd0, 1'b0, "R9 read outside grant");
    endtask

    task automatic t_disable;
        reg_wr(10'h000, 32'h100);
        reg_chk(10'h000, 32'h0, "R1 disabled and flag cleared");
        xfer(32'h7000_0000, 1'b1, 1'b0, 2'd3, 1'b1, "R1 disabled passes unmatched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty();
        t_region();
        t_capture();
        t_valid();
        t_alias();
        t_overlap();
        t_disable();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule